// File: doc/BRIEF.md
# Audio Stream Switch Shadow-Load Controller

This block holds the enable and configuration state for two audio interfaces and the DMA channels that feed them. Software writes an interface-enable field and, for each interface, a field of physical-channel enables. These writes do not reach the active state at once. They land in shadow registers and move into the active registers at a synchronisation point, which is a protection-address strobe from the DMA channel that belongs to them. When both interfaces are off there is no stream to disturb, so a write then takes effect at the next clock edge.

Switching works at three levels. A DMA channel enable can drop, and that clears the channel's FIFO and sends its pointers back to their base addresses. The interface-enable field turns whole interfaces on or off. The word-select fields turn single physical channels on or off. An interface that has been enabled waits for the next reset of its time-slot-list pointer before it begins to run. The DMA engine, the FIFOs and the time-slot sequencer are outside this block. It only drives their control pulses and takes their strobes in.

Top module: `asw_switch_ctl`

## Requirements
- R1: While any bit of `act_mode` is 1, a write to the mode field or to a word-select field leaves the active value unchanged and sets the matching pending flag (`mode_pend`, or bit i of `ws_pend`) at the next edge.
- R2: A pending mode value loads on a cycle with any bit of `prot_hit` set. A pending word-select value for interface i loads only when `prot_hit[i]` is set. Either load clears the pending flag.
- R3: While `act_mode` is all zero, a write loads into the active register at the next clock edge and leaves no pending flag.
- R4: A second write before the load replaces the pending value, and only the last written value reaches the active register.
- R5: If a write and its synchronising strobe fall in the same cycle while a value is pending, the older pending value loads and the new value stays pending.
- R6: `if_run[i]` rises, together with a one-cycle `if_start[i]` pulse, at the edge that samples `tsl_reset[i]` high while `act_mode[i]` is already 1. A `tsl_reset[i]` pulse in the cycle of the mode write does not count. `if_run[i]` falls one edge after `act_mode[i]` becomes 0.
- R7: When `dma_en[i]` is first sampled low after being high, `fifo_clr[i]` and `ptr_reload[i]` are both 1 for exactly the next cycle.
- R8: After reset, all active fields, pending flags, run flags and pulses are zero.
- R9: Bit i of the mode field enables interface i. The word-select field of interface i sits at bits [i*WS_W +: WS_W] of `act_ws`. `cfg_we_ws[i]` selects which field `cfg_ws_data` writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we_mode | input | 1 | Write strobe for the interface-enable field |
| cfg_mode | input | NUM_IF | Interface-enable write data |
| cfg_we_ws | input | NUM_IF | Per-interface write strobe for the word-select field |
| cfg_ws_data | input | WS_W | Word-select write data |
| prot_hit | input | NUM_IF | Protection-address-reached strobe per DMA channel |
| tsl_reset | input | NUM_IF | Time-slot-list pointer reset pulse per interface |
| dma_en | input | NUM_IF | DMA channel enable per interface |
| act_mode | output | NUM_IF | Active interface-enable field |
| act_ws | output | NUM_IF*WS_W | Active word-select fields, concatenated |
| mode_pend | output | 1 | Mode shadow holds an unloaded value |
| ws_pend | output | NUM_IF | Word-select shadow holds an unloaded value |
| if_run | output | NUM_IF | Interface is running |
| if_start | output | NUM_IF | One-cycle pulse when an interface starts running |
| fifo_clr | output | NUM_IF | One-cycle FIFO clear pulse |
| ptr_reload | output | NUM_IF | One-cycle DMA pointer reload pulse |

## Verification
Two events can land in the same cycle: a software write to a shadowed field and the protection-address strobe that loads it. The bench first leaves a value pending. It then raises the write strobe and `prot_hit` in the same clock and checks that the active field takes the older value while the pending flag stays set. A later strobe must then deliver the newer value. A second collision puts a time-slot-list reset in the cycle of the enabling write, and the bench judges that no start happens until the next pointer reset.

// File: rtl/asw_pkg.sv
package asw_pkg;

    // DMA teardown pulse pair issued for one channel
    typedef struct packed {
        logic clr;
        logic reload;
    } asw_teardown_t;

    // Start-controller state for one interface
    typedef struct packed {
        logic run;
        logic start;
    } asw_start_t;

endpackage

// File: rtl/asw_shadow_slot.sv
module asw_shadow_slot #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         sync,
    input  logic         idle,
    output logic [W-1:0] act,
    output logic         pend
);

    typedef struct packed {
        logic [W-1:0] shd;
        logic [W-1:0] act;
        logic         pend;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (idle && we) begin
            // nothing is streaming: bypass the deferral
            st_d.act  = wdata;
            st_d.shd  = wdata;
            st_d.pend = 1'b0;
        end else begin
            if (sync && st_q.pend) begin
                st_d.act  = st_q.shd;
                st_d.pend = 1'b0;
            end
            if (we) begin
                // new write waits for the next strobe
                st_d.shd  = wdata;
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act  = st_q.act;
    assign pend = st_q.pend;

endmodule

// File: rtl/asw_start_ctrl.sv
module asw_start_ctrl
    import asw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tsl_rst,
    output logic run,
    output logic start
);

    asw_start_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = en && !st_q.run && tsl_rst;
        if (!en)          st_d.run = 1'b0;
        else if (tsl_rst) st_d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run   = st_q.run;
    assign start = st_q.start;

endmodule

// File: rtl/asw_dma_off.sv
module asw_dma_off
    import asw_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] dma_en,
    output logic [N-1:0] fifo_clr,
    output logic [N-1:0] ptr_reload
);

    typedef struct packed {
        logic          [N-1:0] en;
        asw_teardown_t [N-1:0] td;
    } off_t;

    off_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = dma_en;
        for (int i = 0; i < N; i++) begin
            st_d.td[i].clr    = st_q.en[i] && !dma_en[i];
            st_d.td[i].reload = st_q.en[i] && !dma_en[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_out
        assign fifo_clr[g]   = st_q.td[g].clr;
        assign ptr_reload[g] = st_q.td[g].reload;
    end

endmodule

// File: rtl/asw_switch_ctl.sv
module asw_switch_ctl #(
    parameter int NUM_IF = 2,
    parameter int WS_W   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we_mode,
    input  logic [NUM_IF-1:0]      cfg_mode,
    input  logic [NUM_IF-1:0]      cfg_we_ws,
    input  logic [WS_W-1:0]        cfg_ws_data,
    input  logic [NUM_IF-1:0]      prot_hit,
    input  logic [NUM_IF-1:0]      tsl_reset,
    input  logic [NUM_IF-1:0]      dma_en,
    output logic [NUM_IF-1:0]      act_mode,
    output logic [NUM_IF*WS_W-1:0] act_ws,
    output logic                   mode_pend,
    output logic [NUM_IF-1:0]      ws_pend,
    output logic [NUM_IF-1:0]      if_run,
    output logic [NUM_IF-1:0]      if_start,
    output logic [NUM_IF-1:0]      fifo_clr,
    output logic [NUM_IF-1:0]      ptr_reload
);

    localparam int WS_TOT = NUM_IF * WS_W;

    logic idle;
    logic mode_sync;

    // both interfaces off: writes bypass the shadow
    assign idle      = (act_mode == '0);
    // the mode field spans all interfaces, so any channel strobe loads it
    assign mode_sync = |prot_hit;

    asw_shadow_slot #(.W(NUM_IF)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we_mode),
        .wdata (cfg_mode),
        .sync  (mode_sync),
        .idle  (idle),
        .act   (act_mode),
        .pend  (mode_pend)
    );

    for (genvar g = 0; g < NUM_IF; g++) begin : g_if
        asw_shadow_slot #(.W(WS_W)) u_ws (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (cfg_we_ws[g]),
            .wdata (cfg_ws_data),
            .sync  (prot_hit[g]),
            .idle  (idle),
            .act   (act_ws[g*WS_W +: WS_W]),
            .pend  (ws_pend[g])
        );

        asw_start_ctrl u_start (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (act_mode[g]),
            .tsl_rst (tsl_reset[g]),
            .run     (if_run[g]),
            .start   (if_start[g])
        );
    end

    asw_dma_off #(.N(NUM_IF)) u_dma (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_en     (dma_en),
        .fifo_clr   (fifo_clr),
        .ptr_reload (ptr_reload)
    );

    logic [WS_TOT-1:0] unused_ws_chk;
    assign unused_ws_chk = act_ws;

endmodule

// File: rtl/asw_switch_ctl_chk.sv
module asw_switch_ctl_chk #(
    parameter int NUM_IF = 2,
    parameter int WS_W   = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we_mode,
    input logic [NUM_IF-1:0]      cfg_mode,
    input logic [NUM_IF-1:0]      cfg_we_ws,
    input logic [WS_W-1:0]        cfg_ws_data,
    input logic [NUM_IF-1:0]      prot_hit,
    input logic [NUM_IF-1:0]      tsl_reset,
    input logic [NUM_IF-1:0]      dma_en,
    input logic [NUM_IF-1:0]      act_mode,
    input logic [NUM_IF*WS_W-1:0] act_ws,
    input logic                   mode_pend,
    input logic [NUM_IF-1:0]      ws_pend,
    input logic [NUM_IF-1:0]      if_run,
    input logic [NUM_IF-1:0]      if_start,
    input logic [NUM_IF-1:0]      fifo_clr,
    input logic [NUM_IF-1:0]      ptr_reload
);

    // R1: active mode write with no strobe is deferred
    p_defer_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_mode && act_mode != '0 && prot_hit == '0)
        |=> (mode_pend && $stable(act_mode)));

    // R2: strobe without a competing write empties the mode shadow
    p_sync_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_hit != '0 && !cfg_we_mode) |=> !mode_pend);

    // R3: idle write lands at once
    p_idle_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_mode && act_mode == '0)
        |=> (act_mode == $past(cfg_mode) && !mode_pend));

    // R6: start only after a pointer reset while enabled
    p_start_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (if_start != '0)
        |-> ((if_start & ~($past(tsl_reset) & $past(act_mode))) == '0));

    // R6: start pulse accompanies run
    p_start_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((if_start & ~if_run) == '0));

    // R7: teardown pulses always paired
    p_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clr == ptr_reload));

    // R7: teardown pulse lasts one cycle
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clr != '0) |=> ((fifo_clr & $past(fifo_clr)) == '0));

endmodule

bind asw_switch_ctl asw_switch_ctl_chk #(.NUM_IF(NUM_IF), .WS_W(WS_W)) u_chk (.*);

// File: tb/asw_switch_ctl_test.sv
`timescale 1ns/1ps
module asw_switch_ctl_test;

    localparam int NUM_IF = 2;
    localparam int WS_W   = 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   cfg_we_mode = 1'b0;
    logic [NUM_IF-1:0]      cfg_mode = '0;
    logic [NUM_IF-1:0]      cfg_we_ws = '0;
    logic [WS_W-1:0]        cfg_ws_data = '0;
    logic [NUM_IF-1:0]      prot_hit = '0;
    logic [NUM_IF-1:0]      tsl_reset = '0;
    logic [NUM_IF-1:0]      dma_en = '0;
    logic [NUM_IF-1:0]      act_mode;
    logic [NUM_IF*WS_W-1:0] act_ws;
    logic                   mode_pend;
    logic [NUM_IF-1:0]      ws_pend;
    logic [NUM_IF-1:0]      if_run;
    logic [NUM_IF-1:0]      if_start;
    logic [NUM_IF-1:0]      fifo_clr;
    logic [NUM_IF-1:0]      ptr_reload;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    asw_switch_ctl #(.NUM_IF(NUM_IF), .WS_W(WS_W)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // all driving happens here; outputs read after the edge just passed
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_ws(input int idx, input logic [WS_W-1:0] v);
        cfg_we_ws[idx] = 1'b1;
        cfg_ws_data    = v;
        cyc();
        cfg_we_ws = '0;
    endtask

    task automatic wr_mode(input logic [NUM_IF-1:0] v);
        cfg_we_mode = 1'b1;
        cfg_mode    = v;
        cyc();
        cfg_we_mode = 1'b0;
    endtask

    task automatic strobe(input logic [NUM_IF-1:0] p);
        prot_hit = p;
        cyc();
        prot_hit = '0;
    endtask

    task automatic t_reset();
        chk("R8 act_mode", 32'(act_mode), 0);
        chk("R8 act_ws", 32'(act_ws), 0);
        chk("R8 pend", 32'({mode_pend, ws_pend}), 0);
        chk("R8 run", 32'({if_run, if_start}), 0);
        chk("R8 teardown", 32'({fifo_clr, ptr_reload}), 0);
    endtask

    task automatic t_idle();
        wr_ws(0, 4'hA);
        chk("R3 idle ws0 load", 32'(act_ws), 32'h0A);
        chk("R3 idle no pend", 32'(ws_pend), 0);
        wr_ws(1, 4'h5);
        chk("R9 ws1 field position", 32'(act_ws), 32'h5A);
        // enabling write collides with a pointer reset
        tsl_reset = 2'b01;
        wr_mode(2'b01);
        tsl_reset = '0;
        chk("R3 idle mode load", 32'(act_mode), 32'h1);
        chk("R3 idle mode no pend", 32'(mode_pend), 0);
        chk("R6 no start on write cycle", 32'(if_run), 0);
    endtask

    task automatic t_start();
        tsl_reset = 2'b11;
        cyc();
        tsl_reset = '0;
        chk("R6 run after tsl reset", 32'(if_run), 32'h1);
        chk("R6 start pulse", 32'(if_start), 32'h1);
        cyc();
        chk("R6 start one cycle", 32'(if_start), 0);
        chk("R6 run held", 32'(if_run), 32'h1);
    endtask

    task automatic t_defer();
        wr_ws(0, 4'h3);
        chk("R1 ws0 deferred", 32'(act_ws), 32'h5A);
        chk("R1 ws0 pending", 32'(ws_pend), 32'h1);
        cyc();
        chk("R1 still deferred", 32'(act_ws), 32'h5A);
        strobe(2'b10);
        chk("R2 other channel strobe ignored", 32'(act_ws), 32'h5A);
        chk("R2 other strobe pend kept", 32'(ws_pend), 32'h1);
        strobe(2'b01);
        chk("R2 own strobe loads", 32'(act_ws), 32'h53);
        chk("R2 pend cleared", 32'(ws_pend), 0);
    endtask

    task automatic t_overwrite();
        wr_ws(1, 4'h7);
        wr_ws(1, 4'h9);
        chk("R4 still old", 32'(act_ws), 32'h53);
        chk("R4 pending", 32'(ws_pend), 32'h2);
        strobe(2'b10);
        chk("R4 last value loads", 32'(act_ws), 32'h93);
    endtask

    task automatic t_collide();
        wr_ws(0, 4'hC);
        cfg_we_ws   = 2'b01;
        cfg_ws_data = 4'hE;
        prot_hit    = 2'b01;
        cyc();
        cfg_we_ws = '0;
        prot_hit  = '0;
        chk("R5 older value loads", 32'(act_ws), 32'h9C);
        chk("R5 newer stays pending", 32'(ws_pend), 32'h1);
        strobe(2'b01);
        chk("R5 newer loads later", 32'(act_ws), 32'h9E);
    endtask

    task automatic t_mode();
        wr_mode(2'b11);
        chk("R1 mode deferred", 32'(act_mode), 32'h1);
        chk("R1 mode pending", 32'(mode_pend), 32'h1);
        strobe(2'b10);
        chk("R2 mode loads on any strobe", 32'(act_mode), 32'h3);
        chk("R6 if1 waits for reset", 32'(if_run), 32'h1);
        tsl_reset = 2'b10;
        cyc();
        tsl_reset = '0;
        chk("R6 if1 started", 32'(if_run), 32'h3);
        chk("R6 if1 start pulse", 32'(if_start), 32'h2);
        wr_mode(2'b00);
        strobe(2'b01);
        chk("R2 mode off loaded", 32'(act_mode), 0);
        chk("R6 run one edge later", 32'(if_run), 32'h3);
        cyc();
        chk("R6 run dropped", 32'(if_run), 0);
        wr_ws(0, 4'h1);
        chk("R3 idle again immediate", 32'(act_ws), 32'h91);
    endtask

    task automatic t_dma();
        dma_en = 2'b11;
        cyc();
        cyc();
        chk("R7 no pulse on enable", 32'(fifo_clr), 0);
        dma_en = 2'b01;
        cyc();
        chk("R7 clr ch1", 32'(fifo_clr), 32'h2);
        chk("R7 reload ch1", 32'(ptr_reload), 32'h2);
        cyc();
        chk("R7 single pulse", 32'({fifo_clr, ptr_reload}), 0);
        dma_en = 2'b00;
        cyc();
        chk("R7 clr ch0", 32'({fifo_clr, ptr_reload}), 32'h5);
        cyc();
        chk("R7 ch0 pulse ends", 32'({fifo_clr, ptr_reload}), 0);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_idle();
        t_start();
        t_defer();
        t_overwrite();
        t_collide();
        t_mode();
        t_dma();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule